// File: doc/BRIEF.md
# TDM Serial Audio Slot Receiver

This block takes one serial audio data line and assembles time-division slots into a 24-bit word that a host reads. The block is clocked by the serial bit clock itself. A frame-active level qualifies which bit-clock edges carry data. On each active edge, one bit enters a 32-bit shift register. When the programmed number of bits has arrived, the word is placed in a read-only output register, a full flag is raised, and an interrupt follows if it is unmasked.

Three settings control how a slot is mapped into the 24-bit register: the slot length, the bit order, and an alignment mode that places the word at bit 15 and clears the top byte. These three settings are captured only while the receiver is disabled. A rising edge of the frame-active level always starts a new slot. This lets a receiver that lost its place recover at the next frame. If a word arrives before the previous one has been read, the new word replaces it and a sticky overrun flag is raised.

Top module: `tdm_slot_rx`

## Requirements
- R1: A bit is taken from `sd_i` only on a `clk_i` rising edge where `en_i` and `fs_i` are both 1. Edges with either of them at 0 add no bit to the slot.
- R2: With `lsb_first_i`=0 the first received bit of a slot is the word's most significant bit. With `lsb_first_i`=1 the first received bit is the least significant bit.
- R3: `len_sel_i` selects the slot length as 0:8, 1:12, 2:16, 3:20, 4:24, 5 to 7:32 bits. The register updates at the edge that samples the slot's last bit.
- R4: When alignment mode is off, a word of up to 24 bits sits in `data_o[23:24-L]`, and the bits below it read as 0.
- R5: When `align16_i`=1, `data_o[23:16]` reads 0. The 16 most significant bits of the word go to `data_o[15:0]`. A shorter word is placed at bit 15, with zeros below it.
- R6: For a 32-bit slot, the 24 most significant bits of the received word are kept and the other 8 are dropped.
- R7: `full_o` is set by every word load and cleared by `rd_i`. If a load and `rd_i` happen on the same edge, the flag stays set.
- R8: `irq_o` is 1 exactly when `full_o` and `irq_en_i` are both 1.
- R9: A load while `full_o`=1 and `rd_i`=0 overwrites `data_o` and sets `ovr_o`. `ovr_o` stays set until an edge with `rd_i`=1.
- R10: A rising edge of `fs_i` discards any partially received bits, and that edge's bit becomes bit one of a new slot. Lowering `en_i` also discards the partial slot.
- R11: `len_sel_i`, `lsb_first_i` and `align16_i` are captured on edges where `en_i`=0. While `en_i`=1, changes to them have no effect.
- R12: After reset, `data_o`, `full_o`, `ovr_o` and `irq_o` are 0, and the captured settings are 8-bit slots, MSB first, with alignment off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| fs_i | input | 1 | Frame-active level |
| sd_i | input | 1 | Serial data |
| len_sel_i | input | 3 | Slot length select |
| lsb_first_i | input | 1 | Bit order: 1 = LSB first |
| align16_i | input | 1 | Align word to bit 15, top byte zero |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Read strobe for the data register |
| data_o | output | 24 | Received data word |
| full_o | output | 1 | Data register holds an unread word |
| irq_o | output | 1 | Receive interrupt |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter shows up as a load that comes at the wrong edge. A `full_o` rise that is one bit clock early or late is caught within a single slot. A wrong shift direction, mask or alignment shows up as a mismatch in `data_o` on the first load after the error. A wrong value in the captured settings shows on the next word. A flag error shows up as `full_o` or `ovr_o` differing from the reference model on the edge after the stimulus that should have set or cleared it.

// File: rtl/tdm_slot_rx_pkg.sv
package tdm_slot_rx_pkg;
  localparam int DATA_W  = 24;
  localparam int SHIFT_W = 32;
  localparam int ALIGN_W = 16;
  localparam int CNT_W   = $clog2(SHIFT_W + 1);
  localparam int SEL_W   = 3;

  typedef struct packed {
    logic [SEL_W-1:0] len_sel;
    logic             lsb_first;
    logic             align16;
  } rx_cfg_t;

  function automatic logic [CNT_W-1:0] slot_bits(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(SHIFT_W);
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_cfg.sv
module tdm_rx_cfg
  import tdm_slot_rx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  rx_cfg_t cfg_i,
  output rx_cfg_t cfg_o
);
  // settings only move while the receiver is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_o <= '0;
    else if (!en_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift
  import tdm_slot_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fs_i,
  input  logic              sd_i,
  input  rx_cfg_t           cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  logic [CNT_W-1:0]   cnt_q, cnt_base, cnt_inc, len, shamt;
  logic [SHIFT_W-1:0] sh_q, sh_nxt, aligned, mask;
  logic               fs_q, rise;

  assign len      = slot_bits(cfg_i.len_sel);
  assign rise     = fs_i & ~fs_q;
  assign cnt_base = rise ? '0 : cnt_q;
  assign cnt_inc  = cnt_base + CNT_W'(1);
  assign done_o   = en_i & fs_i & (cnt_inc == len);

  assign sh_nxt = cfg_i.lsb_first ? {sd_i, sh_q[SHIFT_W-1:1]}
                                  : {sh_q[SHIFT_W-2:0], sd_i};

  // bring the word to the top of the 32-bit field, stale bits cleared
  assign shamt   = CNT_W'(SHIFT_W) - len;
  assign mask    = {SHIFT_W{1'b1}} << shamt;
  assign aligned = cfg_i.lsb_first ? (sh_nxt & mask) : (sh_nxt << shamt);
  assign word_o  = aligned[SHIFT_W-1 -: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      fs_q <= fs_i;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (fs_i) begin
        cnt_q <= done_o ? '0 : cnt_inc;
        sh_q  <= sh_nxt;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_dreg.sv
module tdm_rx_dreg
  import tdm_slot_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rd_i,
  input  logic              align16_i,
  input  logic              irq_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_nxt;

  assign data_nxt = align16_i ? {{(DATA_W-ALIGN_W){1'b0}}, word_i[DATA_W-1 -: ALIGN_W]}
                              : word_i;
  assign irq_o    = full_o & irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (load_i) data_o <= data_nxt;
      if (load_i)    full_o <= 1'b1;
      else if (rd_i) full_o <= 1'b0;
      if (load_i && full_o && !rd_i) ovr_o <= 1'b1;
      else if (rd_i)                 ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fs_i,
  input  logic              sd_i,
  input  logic [SEL_W-1:0]  len_sel_i,
  input  logic              lsb_first_i,
  input  logic              align16_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovr_o
);
  rx_cfg_t           cfg_in, cfg_q;
  logic              load;
  logic [DATA_W-1:0] word;
  logic              cfg_align;

  assign cfg_in    = '{len_sel: len_sel_i, lsb_first: lsb_first_i, align16: align16_i};
  assign cfg_align = cfg_q.align16;

  tdm_rx_cfg u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .cfg_i (cfg_in), .cfg_o(cfg_q)
  );

  tdm_rx_shift u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .fs_i(fs_i), .sd_i(sd_i),
    .cfg_i (cfg_q), .done_o(load), .word_o(word)
  );

  tdm_rx_dreg u_dreg (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .rd_i(rd_i),
    .align16_i(cfg_align), .irq_en_i(irq_en_i), .word_i(word),
    .data_o(data_o), .full_o(full_o), .irq_o(irq_o), .ovr_o(ovr_o)
  );
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk
  import tdm_slot_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_i,
  input logic              irq_en_i,
  input logic              load_i,
  input logic              align_i,
  input logic [DATA_W-1:0] data_i,
  input logic              full_i,
  input logic              irq_i,
  input logic              ovr_i
);
  a_r7_load_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_i);
  a_r7_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i) |=> !full_i);
  a_r8_irq_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (full_i && irq_en_i));
  a_r9_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && full_i && !rd_i) |=> ovr_i);
  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !rd_i) |=> ovr_i);
  a_r5_top_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && align_i) |=> (data_i[DATA_W-1 -: DATA_W-ALIGN_W] == '0));
  a_r1_idle_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_i));
endmodule

bind tdm_slot_rx tdm_slot_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rd_i(rd_i), .irq_en_i(irq_en_i),
  .load_i(load), .align_i(cfg_align), .data_i(data_o), .full_i(full_o),
  .irq_i(irq_o), .ovr_i(ovr_o)
);

// File: tb/sim_tdm_slot_rx.sv
module sim_tdm_slot_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, fs = 1'b0, sd = 1'b0, lsb = 1'b0, al = 1'b0, ien = 1'b0, rd = 1'b0;
  logic [2:0]  lsel = 3'd0;
  logic [23:0] data;
  logic        full, irq, ovr;

  int checks = 0, fails = 0;
  string scen = "R12";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fs_i(fs), .sd_i(sd),
    .len_sel_i(lsel), .lsb_first_i(lsb), .align16_i(al), .irq_en_i(ien),
    .rd_i(rd), .data_o(data), .full_o(full), .irq_o(irq), .ovr_o(ovr)
  );

  // behavioural reference
  int          q[$];
  logic [23:0] m_data;
  bit          m_full, m_ovr, m_fsp;
  int          m_len;
  bit          m_lsb, m_al;

  function automatic int len_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_data = '0; m_full = 0; m_ovr = 0; m_fsp = 0;
      m_len = 8; m_lsb = 0; m_al = 0;
    end else begin
      bit ld;
      longint v;
      ld = 0;
      if (en) begin
        if (fs) begin
          if (!m_fsp) q.delete();
          q.push_back(int'(sd));
          if (q.size() == m_len) begin
            v = 0;
            for (int i = 0; i < m_len; i++)
              if (q[i] != 0) v |= m_lsb ? (64'd1 << i) : (64'd1 << (m_len-1-i));
            if (m_len == 32) v = v >> 8;
            else             v = v << (24 - m_len);
            if (m_al) v = v >> 8;
            ld = 1;
            q.delete();
          end
        end
      end else begin
        q.delete();
      end
      if (ld && m_full && !rd) m_ovr = 1;
      else if (rd)             m_ovr = 0;
      if (ld) begin m_data = v[23:0]; m_full = 1; end
      else if (rd) m_full = 0;
      if (!en) begin m_len = len_of(lsel); m_lsb = lsb; m_al = al; end
      m_fsp = fs;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(scen, data, m_data);
    chk("R7",  full, m_full);
    chk("R8",  irq,  m_full && ien);
    chk("R9",  ovr,  m_ovr);
  endtask

  // compare at negedge, then drive the next cycle
  task automatic step(input bit e, input bit f, input bit d, input bit r);
    @(negedge clk);
    cmp_all();
    en = e; fs = f; sd = d; rd = r;
  endtask

  task automatic set_cfg(input logic [2:0] s, input bit l, input bit a);
    step(0, 0, 0, 0);
    lsel = s; lsb = l; al = a;
    step(0, 0, 0, 0);
  endtask

  task automatic run_bits(input int n, input int rd_pct);
    for (int i = 0; i < n; i++)
      step(1, 1, 1'($urandom), ($urandom % 100) < rd_pct);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R12: reset values
    chk("R12", data, 0); chk("R12", full, 0); chk("R12", ovr, 0); chk("R12", irq, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    // R3 default 8-bit MSB slot, known pattern 0xA5 -> 0xA50000
    scen = "R3";
    step(1, 1, 1, 0); step(1, 1, 0, 0); step(1, 1, 1, 0); step(1, 1, 0, 0);
    step(1, 1, 0, 0); step(1, 1, 1, 0); step(1, 1, 0, 0); step(1, 1, 1, 0);
    step(1, 0, 0, 0);
    chk("R3", data, 24'hA50000); chk("R4", data[15:0], 0);
    ien = 1;
    step(1, 0, 0, 0);
    chk("R8", irq, 1);
    step(1, 0, 0, 1);
    // R2: LSB first, 8 bits 1,0,0,0,0,0,0,0 -> 0x01
    scen = "R2";
    set_cfg(3'd0, 1, 0);
    step(1, 1, 1, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    chk("R2", data, 24'h010000);
    // sweep all modes
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 2; l++)
        for (int a = 0; a < 2; a++) begin
          if (a) scen = "R5";
          else if (s >= 5) scen = "R6";
          else if (l) scen = "R2";
          else scen = "R4";
          set_cfg(3'(s), l[0], a[0]);
          run_bits(3 * len_of(3'(s)) + 5, 40);
          step(1, 0, 0, 1);
        end
    // R9 overrun with no reads
    scen = "R9";
    set_cfg(3'd0, 0, 0);
    run_bits(40, 0);
    step(1, 0, 0, 0);
    chk("R9", ovr, 1);
    step(1, 0, 0, 1);
    step(1, 0, 0, 0);
    chk("R9", ovr, 0);
    // R1: gaps in fs, no bits taken
    scen = "R1";
    for (int i = 0; i < 60; i++) step(1, ($urandom % 3) != 0, 1'($urandom), ($urandom % 4) == 0);
    // R10: misaligned frame recovery
    scen = "R10";
    set_cfg(3'd1, 0, 0);
    run_bits(5, 0);
    step(1, 0, 0, 1);
    run_bits(12, 0);
    step(1, 0, 0, 0);
    chk("R10", full, 1);
    step(1, 0, 0, 1);
    run_bits(7, 0);
    step(0, 0, 0, 0);
    run_bits(12, 50);
    // R11: setting changes while enabled ignored
    scen = "R11";
    set_cfg(3'd2, 0, 0);
    step(1, 0, 0, 1);
    lsel = 3'd0; lsb = 1; al = 1;
    run_bits(50, 30);
    step(1, 0, 0, 0);
    // R7: load and read on same edge keeps full
    set_cfg(3'd0, 0, 0);
    run_bits(7, 0);
    step(1, 1, 1, 1);
    step(1, 0, 0, 0);
    chk("R7", full, 1);
    ien = 0;
    step(1, 0, 0, 0);
    chk("R8", irq, 0);
    step(1, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule